// File: doc/BRIEF.md
# Branch and Jump Next-PC Unit

This unit resolves the control-flow instructions of a 16-bit processor. Each cycle it reads the instruction word, the already-incremented program counter, the three condition flags (negative, zero, positive) and the value that the register file returns for the base register. From these it computes the address of the next instruction, whether control flow was redirected, and whether the return address has to be written into the link register R7.

Three opcodes are recognised. A conditional branch (`0000`) tests a three-bit mask against the flags. A register jump (`1100`) loads the PC from the base register, which makes it a subroutine return when the base register is R7. A subroutine call (`0100`) uses a single bit to choose between a PC-relative target and a base-register target, and both forms link. Every other opcode passes the incremented PC through unchanged. The register file decodes the base-register field itself. All outputs are registered, so a result appears one clock after its inputs.

Top module: `npc_unit`

## Requirements
- R1: For opcode `0000`, the branch is taken when (instr[11] and N) or (instr[10] and Z) or (instr[9] and P) holds. When it is not taken, next_pc equals pc_inc and taken is 0.
- R2: A taken branch sets next_pc to pc_inc plus instr[8:0] sign-extended to 16 bits, modulo 2^16, and sets taken to 1.
- R3: A branch with instr[11:9] = `000` is never taken, whatever the flags are.
- R4: For opcode `1100`, next_pc equals base_val, taken is 1 and link_we is 0. With base field instr[8:6] = 7, this serves as the return.
- R5: For opcode `0100` with instr[11] = 1, next_pc is pc_inc plus instr[10:0] sign-extended to 16 bits, modulo 2^16, and taken is 1.
- R6: For opcode `0100` with instr[11] = 0, next_pc equals base_val as presented in the same cycle, taken is 1. When the base is R7, this is the value from before the link write.
- R7: Both call forms set link_we to 1, link_data to pc_inc and link_sel to 7.
- R8: Every opcode other than `0000`, `0100` and `1100` gives next_pc = pc_inc, taken = 0 and link_we = 0.
- R9: Outputs are registered. Results appear on the clock edge after the inputs are sampled. A synchronous active-high reset clears next_pc, taken, link_we and link_data to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr_i | input | 16 | Instruction word |
| pc_inc_i | input | 16 | Incremented program counter |
| flag_n_i | input | 1 | Negative flag |
| flag_z_i | input | 1 | Zero flag |
| flag_p_i | input | 1 | Positive flag |
| base_val_i | input | 16 | Value read from the base register named by instr[8:6] |
| next_pc_o | output | 16 | Next program counter |
| taken_o | output | 1 | Control flow redirected |
| link_we_o | output | 1 | Write enable for the link register |
| link_sel_o | output | 3 | Index of the link register (always 7) |
| link_data_o | output | 16 | Return address to write |

## Verification
The hardest cases to reach are the targets that wrap past the ends of the 16-bit address space. They need a PC near 0xFFFF with a positive offset, or a PC near 0 with a negative offset, and the most negative 11-bit offset on a call. The bench drives these as directed vectors. It also sweeps all eight branch masks against each single-flag state, so every term of the condition is exercised alone and the empty mask is checked against every flag. A call through R7 is driven with a base value different from pc_inc, which shows that the target comes from the old register value and not from the link data.

// File: rtl/npc_pkg.sv
package npc_pkg;
  localparam int IW    = 16;
  localparam int OPC_W = 4;
  localparam logic [OPC_W-1:0] OP_BRANCH = 4'b0000;
  localparam logic [OPC_W-1:0] OP_CALL   = 4'b0100;
  localparam logic [OPC_W-1:0] OP_JUMP   = 4'b1100;
  localparam logic [2:0]       LINK_IDX  = 3'd7;
  typedef enum logic [1:0] {K_SEQ, K_BRANCH, K_CALL, K_JUMP} cf_kind_e;
endpackage

// File: rtl/npc_offset.sv
module npc_offset #(
  parameter int XLEN  = 16,
  parameter int OFS_W = 9
) (
  input  logic [XLEN-1:0]  base_i,
  input  logic [OFS_W-1:0] ofs_i,
  output logic [XLEN-1:0]  sum_o
);
  localparam int EXT_W = XLEN - OFS_W;
  logic [XLEN-1:0] ext;
  assign ext   = {{EXT_W{ofs_i[OFS_W-1]}}, ofs_i};
  assign sum_o = base_i + ext;
endmodule

// File: rtl/npc_cond.sv
module npc_cond #(
  parameter int NFLAG = 3
) (
  input  logic [NFLAG-1:0] mask_i,
  input  logic [NFLAG-1:0] flags_i,
  output logic             hit_o
);
  logic [NFLAG-1:0] terms;
  for (genvar g = 0; g < NFLAG; g++) begin : g_term
    assign terms[g] = mask_i[g] & flags_i[g];
  end
  assign hit_o = |terms;
endmodule

// File: rtl/npc_unit.sv
module npc_unit
  import npc_pkg::*;
#(
  parameter int XLEN = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [IW-1:0]   instr_i,
  input  logic [XLEN-1:0] pc_inc_i,
  input  logic            flag_n_i,
  input  logic            flag_z_i,
  input  logic            flag_p_i,
  input  logic [XLEN-1:0] base_val_i,
  output logic [XLEN-1:0] next_pc_o,
  output logic            taken_o,
  output logic            link_we_o,
  output logic [2:0]      link_sel_o,
  output logic [XLEN-1:0] link_data_o
);
  localparam int OPC_LSB = IW - OPC_W;
  localparam int BR_OFS  = 9;
  localparam int JS_OFS  = 11;

  logic [OPC_W-1:0] opc;
  cf_kind_e         kind;
  logic             br_hit;
  logic [XLEN-1:0]  br_tgt, call_tgt;
  logic [XLEN-1:0]  npc_d;
  logic             taken_d, link_d;

  assign opc = instr_i[IW-1:OPC_LSB];

  always_comb begin
    case (opc)
      OP_BRANCH: kind = K_BRANCH;
      OP_CALL:   kind = K_CALL;
      OP_JUMP:   kind = K_JUMP;
      default:   kind = K_SEQ;
    endcase
  end

  npc_cond #(.NFLAG(3)) i_cond (
    .mask_i  (instr_i[11:9]),
    .flags_i ({flag_n_i, flag_z_i, flag_p_i}),
    .hit_o   (br_hit)
  );

  npc_offset #(.XLEN(XLEN), .OFS_W(BR_OFS)) i_br_ofs (
    .base_i (pc_inc_i),
    .ofs_i  (instr_i[BR_OFS-1:0]),
    .sum_o  (br_tgt)
  );

  npc_offset #(.XLEN(XLEN), .OFS_W(JS_OFS)) i_js_ofs (
    .base_i (pc_inc_i),
    .ofs_i  (instr_i[JS_OFS-1:0]),
    .sum_o  (call_tgt)
  );

  always_comb begin
    npc_d   = pc_inc_i;
    taken_d = 1'b0;
    link_d  = 1'b0;
    case (kind)
      K_BRANCH: if (br_hit) begin
        npc_d   = br_tgt;
        taken_d = 1'b1;
      end
      K_CALL: begin
        npc_d   = instr_i[11] ? call_tgt : base_val_i;
        taken_d = 1'b1;
        link_d  = 1'b1;
      end
      K_JUMP: begin
        npc_d   = base_val_i;
        taken_d = 1'b1;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      next_pc_o   <= '0;
      taken_o     <= 1'b0;
      link_we_o   <= 1'b0;
      link_data_o <= '0;
    end else begin
      next_pc_o   <= npc_d;
      taken_o     <= taken_d;
      link_we_o   <= link_d;
      link_data_o <= link_d ? pc_inc_i : '0;
    end
  end

  assign link_sel_o = LINK_IDX;

  // Assertions
  logic past_ok;
  always_ff @(posedge clk) begin
    if (rst) past_ok <= 1'b0;
    else     past_ok <= 1'b1;
  end

  // R1: an untaken result always carries the incremented PC
  p_untaken_seq_r1: assert property (@(posedge clk) disable iff (rst)
    (past_ok && !taken_o) |-> next_pc_o == $past(pc_inc_i));

  // R3: empty mask never redirects
  p_empty_mask_r3: assert property (@(posedge clk) disable iff (rst)
    (past_ok && $past(instr_i[15:12] == 4'b0000 && instr_i[11:9] == 3'b000))
      |-> !taken_o);

  // R4: jump follows base value without linking
  p_jump_base_r4: assert property (@(posedge clk) disable iff (rst)
    (past_ok && $past(instr_i[15:12] == 4'b1100))
      |-> (taken_o && !link_we_o && next_pc_o == $past(base_val_i)));

  // R7: a link write only follows a call and carries the incremented PC
  p_link_call_r7: assert property (@(posedge clk) disable iff (rst)
    (past_ok && link_we_o)
      |-> ($past(instr_i[15:12]) == 4'b0100 && link_data_o == $past(pc_inc_i)));

  // R8: other opcodes neither redirect nor link
  p_other_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    (past_ok && $past(instr_i[15:12] != 4'b0000 && instr_i[15:12] != 4'b0100
                      && instr_i[15:12] != 4'b1100))
      |-> (!taken_o && !link_we_o));
endmodule

// File: tb/test_npc_unit.sv
module test_npc_unit;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst;
  logic [15:0] instr, pc_inc, base_val;
  logic        fn, fz, fp;
  logic [15:0] next_pc, link_data;
  logic        taken, link_we;
  logic [2:0]  link_sel;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_P/2) clk = ~clk;

  npc_unit i_npc_unit (
    .clk(clk), .rst(rst), .instr_i(instr), .pc_inc_i(pc_inc),
    .flag_n_i(fn), .flag_z_i(fz), .flag_p_i(fp), .base_val_i(base_val),
    .next_pc_o(next_pc), .taken_o(taken), .link_we_o(link_we),
    .link_sel_o(link_sel), .link_data_o(link_data)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] sx9(input logic [8:0] v);
    return {{7{v[8]}}, v};
  endfunction
  function automatic logic [15:0] sx11(input logic [10:0] v);
    return {{5{v[10]}}, v};
  endfunction

  task automatic step(input logic [15:0] ins, input logic [15:0] pc,
                      input logic [2:0] nzp, input logic [15:0] b);
    @(negedge clk);
    instr = ins; pc_inc = pc; {fn, fz, fp} = nzp; base_val = b;
    @(posedge clk);
    #1;
  endtask

  task automatic expect_out(input string tag, input logic [15:0] npc,
                            input logic tk, input logic lw, input logic [15:0] ld);
    chk({tag, " next_pc"}, next_pc, npc);
    chk({tag, " taken"}, {15'd0, taken}, {15'd0, tk});
    chk({tag, " link_we"}, {15'd0, link_we}, {15'd0, lw});
    if (lw) begin
      chk({tag, " link_data"}, link_data, ld);
      chk({tag, " link_sel"}, {13'd0, link_sel}, 16'd7);
    end
  endtask

  task automatic t_reset;
    rst = 1'b1;
    step(16'h4FFF, 16'h1234, 3'b111, 16'h5555);
    step(16'h4FFF, 16'h1234, 3'b111, 16'h5555);
    expect_out("R9 reset", 16'h0000, 1'b0, 1'b0, 16'h0);
    chk("R9 reset link_data", link_data, 16'h0000);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic t_latency;
    step(16'hC000, 16'h0100, 3'b000, 16'hABCD);
    @(negedge clk);
    instr = 16'h1000; pc_inc = 16'h0200;
    #1;
    chk("R9 held before edge", next_pc, 16'hABCD);
    @(posedge clk); #1;
    chk("R9 updated after edge", next_pc, 16'h0200);
  endtask

  task automatic t_branch_sweep;
    for (int m = 0; m < 8; m++) begin
      for (int f = 0; f < 3; f++) begin
        logic [2:0]  flg;
        logic        tk;
        logic [15:0] ins;
        flg = 3'b001 << f;
        tk  = |(m[2:0] & flg);
        ins = {4'b0000, m[2:0], 9'h010};
        step(ins, 16'h3000, flg, 16'h0);
        if (m == 0) expect_out("R3 empty mask", 16'h3000, 1'b0, 1'b0, 16'h0);
        else expect_out("R1 mask vs flags", tk ? 16'h3010 : 16'h3000, tk, 1'b0, 16'h0);
      end
    end
  endtask

  task automatic t_branch_targets;
    step({4'b0000, 3'b111, 9'h005}, 16'hFFFE, 3'b010, 16'h0);
    expect_out("R2 wrap up", 16'hFFFE + sx9(9'h005), 1'b1, 1'b0, 16'h0);
    step({4'b0000, 3'b111, 9'h1FC}, 16'h0001, 3'b100, 16'h0);
    expect_out("R2 wrap down", 16'hFFFD, 1'b1, 1'b0, 16'h0);
    step({4'b0000, 3'b111, 9'h100}, 16'h8000, 3'b001, 16'h0);
    expect_out("R2 min offset", 16'h8000 + sx9(9'h100), 1'b1, 1'b0, 16'h0);
  endtask

  task automatic t_jump;
    step({4'b1100, 3'b000, 3'd3, 6'd0}, 16'h0400, 3'b000, 16'h1234);
    expect_out("R4 jump", 16'h1234, 1'b1, 1'b0, 16'h0);
    step({4'b1100, 3'b000, 3'd7, 6'd0}, 16'h0400, 3'b010, 16'h2F00);
    expect_out("R4 return", 16'h2F00, 1'b1, 1'b0, 16'h0);
  endtask

  task automatic t_call_rel;
    step({4'b0100, 1'b1, 11'h123}, 16'h1000, 3'b000, 16'h7777);
    expect_out("R5 call fwd", 16'h1123, 1'b1, 1'b1, 16'h1000);
    step({4'b0100, 1'b1, 11'h400}, 16'h0200, 3'b000, 16'h7777);
    expect_out("R5 call min wrap", 16'h0200 + sx11(11'h400), 1'b1, 1'b1, 16'h0200);
    chk("R7 link after rel call", link_data, 16'h0200);
  endtask

  task automatic t_call_reg;
    step({4'b0100, 1'b0, 2'b00, 3'd2, 6'd0}, 16'h0500, 3'b000, 16'hBEEF);
    expect_out("R6 call reg", 16'hBEEF, 1'b1, 1'b1, 16'h0500);
    step({4'b0100, 1'b0, 2'b00, 3'd7, 6'd0}, 16'h0600, 3'b000, 16'h4444);
    expect_out("R6 call via R7 old value", 16'h4444, 1'b1, 1'b1, 16'h0600);
    chk("R7 link data", link_data, 16'h0600);
  endtask

  task automatic t_other;
    for (int op = 0; op < 16; op++) begin
      if (op != 0 && op != 4 && op != 12) begin
        step({op[3:0], 12'hFFF}, 16'h0A00 + 16'(op), 3'b111, 16'h9999);
        expect_out("R8 other opcode", 16'h0A00 + 16'(op), 1'b0, 1'b0, 16'h0);
      end
    end
  endtask

  initial begin
    #(CLK_P * 100000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    rst = 1'b1; instr = '0; pc_inc = '0; base_val = '0;
    fn = 1'b0; fz = 1'b0; fp = 1'b0;
    t_reset;
    t_latency;
    t_branch_sweep;
    t_branch_targets;
    t_jump;
    t_call_rel;
    t_call_reg;
    t_other;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule